// File: doc/BRIEF.md
# Keyed-write prescaled watchdog timer

A memory-mapped watchdog with a 16-bit up-counter and a control/status register on a single-cycle 32-bit register bus. Software arms a timeout of N ticks by loading the counter with 65536 minus N and then setting the enable bit. The counter advances once per prescaled tick. A keep-alive reloads the same value. If the count passes 0xFFFF, the block latches an overflow flag, stops counting and raises a reset request. An external mask input can hold that request back.

Register writes are guarded. Each register accepts a write only when the upper data bits carry its own key, so a stray write cannot disturb the timer. Each accepted write is applied three cycles later, to model synchronisation latency. During those cycles a busy flag reads 1, and software must poll it before the next write. A load of 0xFFFF followed by an enable gives a forced restart on the next tick.

Top module: `keyed_wdt`

## Requirements
- R1: After reset the counter reads 0, the control register reads 0 and rst_req is 0.
- R2: Counter register, offset 0. A write whose bits 31:16 are 0x5A5A loads bits 15:0 into the counter. A read returns the count in bits 15:0, with bits 31:16 reading 0.
- R3: Control register, offset 4. A write whose bits 31:8 are 0xA5A5A5 updates the register: bit 7 is the enable, bits 2:0 are the prescale index, and bit 4 written as 0 clears the overflow flag while 1 leaves it unchanged. A read returns bit 7 enable, bit 5 busy, bit 4 overflow and bits 2:0 the index. All other bits read 0.
- R4: A write with a wrong key, or to any other offset, changes no state and does not raise busy.
- R5: An accepted write raises busy for exactly 3 cycles. The new value takes effect on the clock edge that clears busy.
- R6: A write that arrives while busy is 1 is dropped.
- R7: The counter advances by one per prescaled tick, and only while enable is 1. Clearing enable freezes the counter.
- R8: Prescale indices 0 to 7 divide the clock by 1, 4, 16, 32, 64, 128, 1024 and 1024. The divider restarts on every applied write, so the first tick comes N cycles after enable takes effect.
- R9: A tick while the count is 0xFFFF wraps the counter to 0, sets the overflow flag and clears enable.
- R10: On overflow the reset request is active for 16 cycles, starting at the overflow edge. It is driven on rst_req only while rst_mask is 0.
- R11: Reloading the counter while the timer is enabled restarts the timeout from the reloaded value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 4 | Register byte offset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_data | input | 32 | Write data, key in the upper bits |
| rd_data | output | 32 | Read data for reg_addr, combinational |
| rst_mask | input | 1 | 1 blocks the reset request |
| rst_req | output | 1 | System reset request |

## Verification
The assertions check on every cycle that:
- the mask always wins over the reset request;
- a badly keyed or misaddressed write never raises busy, while a good one always does;
- a disabled, idle counter holds its value;
- a reset pulse starts only together with a wrapped, stopped counter and a set overflow flag.

The exact cycle counts can only be shown by the bench scenarios. These cover the three-cycle apply latency, the first-tick delay for each divide ratio, the 16-cycle pulse length, dropped writes during busy, and the point at which a keep-alive restarts the timeout.

// File: rtl/keyed_wdt.sv
module keyed_wdt #(
  parameter int ADDR_W    = 4,
  parameter int BUSY_CYC  = 3,
  parameter int PULSE_CYC = 16,
  parameter int MAX_DIV   = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              wr_en,
  input  logic [31:0]       wr_data,
  output logic [31:0]       rd_data,
  input  logic              rst_mask,
  output logic              rst_req
);
  localparam logic [ADDR_W-1:0] CNT_OFS = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] CTL_OFS = ADDR_W'(4);
  localparam logic [15:0] CNT_KEY = 16'h5A5A;
  localparam logic [23:0] CTL_KEY = 24'hA5A5A5;
  localparam int BUSY_W  = $clog2(BUSY_CYC + 1);
  localparam int PULSE_W = $clog2(PULSE_CYC + 1);
  localparam int PRE_W   = $clog2(MAX_DIV);

  logic [15:0]        cnt_q, pend_val_q;
  logic               en_q, ovf_q, pend_cnt_q, pend_ctl_q;
  logic [2:0]         psel_q;
  logic [BUSY_W-1:0]  busy_q;
  logic [PULSE_W-1:0] pulse_q;
  logic [PRE_W-1:0]   pre_q, div_m1;

  wire busy   = busy_q != '0;
  wire hit_cn = wr_en && !busy && reg_addr == CNT_OFS && wr_data[31:16] == CNT_KEY;
  wire hit_ct = wr_en && !busy && reg_addr == CTL_OFS && wr_data[31:8] == CTL_KEY;
  wire apply  = busy_q == BUSY_W'(1);
  wire tick   = en_q && !apply && pre_q == div_m1;
  wire wrap   = tick && cnt_q == 16'hFFFF;

  always_comb begin
    case (psel_q)
      3'd0:    div_m1 = PRE_W'(0);
      3'd1:    div_m1 = PRE_W'(3);
      3'd2:    div_m1 = PRE_W'(15);
      3'd3:    div_m1 = PRE_W'(31);
      3'd4:    div_m1 = PRE_W'(63);
      3'd5:    div_m1 = PRE_W'(127);
      default: div_m1 = PRE_W'(MAX_DIV - 1);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0; pend_val_q <= '0; pend_cnt_q <= 1'b0; pend_ctl_q <= 1'b0;
      en_q <= 1'b0; ovf_q <= 1'b0; psel_q <= '0;
      busy_q <= '0; pulse_q <= '0; pre_q <= '0;
    end else begin
      if (hit_cn || hit_ct) begin
        busy_q     <= BUSY_W'(BUSY_CYC);
        pend_cnt_q <= hit_cn;
        pend_ctl_q <= hit_ct;
        pend_val_q <= wr_data[15:0];
      end else if (busy) begin
        busy_q <= busy_q - 1'b1;
      end

      if (apply) begin
        pre_q <= '0;
        if (pend_cnt_q) cnt_q <= pend_val_q;
      end else if (en_q) begin
        pre_q <= tick ? '0 : pre_q + 1'b1;
        if (tick) cnt_q <= cnt_q + 1'b1;
      end

      if (wrap) begin
        en_q  <= 1'b0;
        ovf_q <= 1'b1;
      end
      if (apply && pend_ctl_q) begin
        en_q   <= pend_val_q[7];
        psel_q <= pend_val_q[2:0];
        if (!pend_val_q[4]) ovf_q <= 1'b0;
      end

      if (wrap) pulse_q <= PULSE_W'(PULSE_CYC);
      else if (pulse_q != '0) pulse_q <= pulse_q - 1'b1;
    end
  end

  always_comb begin
    case (reg_addr)
      CNT_OFS: rd_data = {16'h0, cnt_q};
      CTL_OFS: rd_data = {24'h0, en_q, 1'b0, busy, ovf_q, 1'b0, psel_q};
      default: rd_data = '0;
    endcase
  end

  assign rst_req = (pulse_q != '0) && !rst_mask;
endmodule

// File: rtl/keyed_wdt_chk.sv
module keyed_wdt_chk #(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [23:0]       key_hi,
  input logic              rst_mask,
  input logic              rst_req,
  input logic              busy,
  input logic [15:0]       cnt_q,
  input logic              en_q,
  input logic              ovf_q,
  input logic              pulse_on
);
  wire good_key = (reg_addr == ADDR_W'(0) && key_hi[23:8] == 16'h5A5A) ||
                  (reg_addr == ADDR_W'(4) && key_hi == 24'hA5A5A5);

  // R10
  mask_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_mask |-> !rst_req);

  // R4
  key_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !busy && !good_key) |=> !busy);

  // R5
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !busy && good_key) |=> busy);

  // R7
  hold_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !busy) |=> $stable(cnt_q));

  // R9
  wrap_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse_on) |-> (ovf_q && !en_q && cnt_q == 16'h0));
endmodule

bind keyed_wdt keyed_wdt_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_addr(reg_addr),
  .key_hi(wr_data[31:8]), .rst_mask(rst_mask), .rst_req(rst_req),
  .busy(busy_q != '0), .cnt_q(cnt_q), .en_q(en_q), .ovf_q(ovf_q),
  .pulse_on(pulse_q != '0)
);

// File: tb/keyed_wdt_bench.sv
module keyed_wdt_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        rst_mask = 1'b0;
  logic [31:0] rd_data;
  logic        rst_req;
  int checks = 0, errors = 0;
  bit done = 0;

  keyed_wdt u_keyed_wdt (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .rst_mask(rst_mask), .rst_req(rst_req)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    reg_addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = rd_data;
  endtask

  task automatic chk_reg(string tag, logic [3:0] a, logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(tag, d, exp);
  endtask

  task automatic t_reset;
    chk_reg("R1 counter", 4'h0, 32'h0);
    chk_reg("R1 control", 4'h4, 32'h0);
    chk("R1 rst_req", {31'h0, rst_req}, 32'h0);
  endtask

  task automatic t_busy_load;
    wr(4'h0, 32'h5A5A_1234);
    chk_reg("R5 busy after E0", 4'h4, 32'h20);
    chk_reg("R5 not yet loaded", 4'h0, 32'h0);
    step(2);
    chk_reg("R5 busy after E2", 4'h4, 32'h20);
    step(1);
    chk_reg("R5 busy clear", 4'h4, 32'h0);
    chk_reg("R2 loaded", 4'h0, 32'h0000_1234);
  endtask

  task automatic t_drop;
    wr(4'h0, 32'h5A5A_1111);
    wr(4'h0, 32'h5A5A_2222);
    step(1);
    chk_reg("R6 first write kept", 4'h0, 32'h0000_1111);
    step(3);
    chk_reg("R6 second write dropped", 4'h0, 32'h0000_1111);
  endtask

  task automatic t_bad_key;
    wr(4'h0, 32'h1234_0055);
    chk_reg("R4 no busy on bad key", 4'h4, 32'h0);
    step(3);
    chk_reg("R4 counter kept", 4'h0, 32'h0000_1111);
    wr(4'h4, 32'hA5A5_A481);
    step(3);
    chk_reg("R4 control kept", 4'h4, 32'h0);
    wr(4'h8, 32'hA5A5_A581);
    chk_reg("R4 other offset no busy", 4'h4, 32'h0);
    step(3);
    chk_reg("R4 other offset reads 0", 4'h8, 32'h0);
    chk_reg("R4 control kept after offset 8", 4'h4, 32'h0);
  endtask

  task automatic t_overflow;
    wr(4'h0, 32'h5A5A_FFF0); step(3);
    wr(4'h4, 32'hA5A5_A580); step(3);
    chk_reg("R3 enable read", 4'h4, 32'h80);
    step(5);
    chk_reg("R7 count div1", 4'h0, 32'h0000_FFF5);
    step(11);
    chk_reg("R9 wrapped to 0", 4'h0, 32'h0);
    chk_reg("R9 ovf set enable cleared", 4'h4, 32'h10);
    chk("R10 rst_req start", {31'h0, rst_req}, 32'h1);
    step(15);
    chk("R10 rst_req cycle 16", {31'h0, rst_req}, 32'h1);
    step(1);
    chk("R10 rst_req ends", {31'h0, rst_req}, 32'h0);
    wr(4'h4, 32'hA5A5_A510); step(3);
    chk_reg("R3 bit4=1 keeps ovf", 4'h4, 32'h10);
    wr(4'h4, 32'hA5A5_A500); step(3);
    chk_reg("R3 bit4=0 clears ovf", 4'h4, 32'h0);
  endtask

  task automatic t_mask;
    rst_mask = 1'b1;
    wr(4'h0, 32'h5A5A_FFFF); step(3);
    wr(4'h4, 32'hA5A5_A580); step(3);
    step(1);
    chk_reg("R9 forced restart ovf", 4'h4, 32'h10);
    chk("R10 masked start", {31'h0, rst_req}, 32'h0);
    step(8);
    chk("R10 masked mid", {31'h0, rst_req}, 32'h0);
    step(12);
    rst_mask = 1'b0;
    wr(4'h4, 32'hA5A5_A500); step(3);
  endtask

  task automatic t_prescale;
    wr(4'h0, 32'h5A5A_FFFE); step(3);
    wr(4'h4, 32'hA5A5_A581); step(3);
    step(4);
    chk_reg("R8 div4 first tick", 4'h0, 32'h0000_FFFF);
    step(3);
    chk_reg("R8 div4 no early wrap", 4'h4, 32'h81);
    step(1);
    chk_reg("R8 div4 wrap", 4'h4, 32'h11);
    step(20);
    wr(4'h0, 32'h5A5A_FFFF); step(3);
    wr(4'h4, 32'hA5A5_A587); step(3);
    step(1023);
    chk_reg("R8 index7 before 1024", 4'h4, 32'h87);
    step(1);
    chk_reg("R8 index7 wraps at 1024", 4'h4, 32'h17);
    step(20);
    wr(4'h4, 32'hA5A5_A500); step(3);
  endtask

  task automatic t_stop;
    logic [31:0] d;
    wr(4'h0, 32'h5A5A_1000); step(3);
    wr(4'h4, 32'hA5A5_A580); step(3);
    step(5);
    chk_reg("R7 counting", 4'h0, 32'h0000_1005);
    wr(4'h4, 32'hA5A5_A500); step(3);
    chk_reg("R7 frozen at apply", 4'h0, 32'h0000_1009);
    step(10);
    rd(4'h0, d);
    chk("R7 stays frozen", d, 32'h0000_1009);
  endtask

  task automatic t_keepalive;
    wr(4'h0, 32'h5A5A_FFF0); step(3);
    wr(4'h4, 32'hA5A5_A580); step(3);
    step(4);
    chk_reg("R11 before reload", 4'h0, 32'h0000_FFF4);
    wr(4'h0, 32'h5A5A_FFF0); step(3);
    chk_reg("R11 reloaded", 4'h0, 32'h0000_FFF0);
    step(15);
    chk_reg("R11 still armed", 4'h4, 32'h80);
    step(1);
    chk_reg("R11 timeout after reload", 4'h4, 32'h10);
    step(20);
  endtask

  initial begin
    step(2);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_busy_load();
    t_drop();
    t_bad_key();
    t_overflow();
    t_mask();
    t_prescale();
    t_stop();
    t_keepalive();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule